// File: doc/BRIEF.md
# Segmented Up/Down Binary Counter with Reversal Restore

This block is a synchronous binary counter that counts up or down by one on each enabled clock. It is meant for wide counts, 64 bits by default, where a carry chain across the whole count would set the clock period. The count is split into equal segments. Each segment keeps two registered flags that describe its own value: all ones and all zeros. A segment steps only when every segment below it carries the matching flag, so a step never ripples through the data bits of more than one segment.

A change of direction is the difficult case for such a counter. To handle it, each segment keeps a shadow copy of the value it held before the last enabled step. When the direction input differs from the direction of the last counting step, every segment swaps its value with its shadow and does no arithmetic. The result is the exact previous count, which is the correct single step in the new direction. A synchronous parallel load, and reset, seed each shadow with the value one step behind the new count in the current direction. This makes a reversal on the very first step correct.

Top module: `ucnt_top`

## Requirements
- R1: While rst_n is low at a clock edge, the count becomes zero and the last-step direction becomes up.
- R2: When load_i is high at a clock edge, count_o takes load_val_i at that edge, whatever en_i is.
- R3: An enabled step with up_i = 1 makes count_o one larger, modulo 2^WIDTH, so all ones goes to zero, and a carry crosses segment boundaries correctly.
- R4: An enabled step with up_i = 0 makes count_o one smaller, modulo 2^WIDTH, so zero goes to all ones, and a borrow crosses segment boundaries correctly.
- R5: An enabled step whose direction differs from the last enabled or loaded direction yields the previous count. Back-to-back reversals alternate between two adjacent values, including across the wrap point.
- R6: With en_i low and load_i low, count_o does not change. A reversal after any number of idle cycles still gives the correct previous count.
- R7: A reversal on the first enabled step after reset or after a load gives the loaded (or zero) value minus one when now counting down, or plus one when now counting up.
- R8: tc_o is high exactly when up_i = 1 and count_o is all ones, or when up_i = 0 and count_o is zero.
- R9: WIDTH must be a whole multiple of SEG. The result of every step matches a plain modular reference counter for any mix of up, down, idle and load cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| en_i | input | 1 | Count enable |
| up_i | input | 1 | Direction: 1 up, 0 down |
| load_i | input | 1 | Parallel load, has priority over en_i |
| load_val_i | input | WIDTH | Value taken on load |
| count_o | output | WIDTH | Current count |
| tc_o | output | 1 | Terminal count for the present direction |

## Verification
The bench builds the counter with WIDTH = 12 and SEG = 4, which gives three segments. This keeps both wrap points and every segment boundary within a few loads and steps. The size is still wide enough that carries and borrows pass through a middle segment that is itself all ones or all zeros. With a 4096-value space, a long pseudo-random run of up, down, idle and load cycles revisits the wrap point and the reversal paths many times. Each cycle of that run is compared with a simple modular model.

// File: rtl/ucnt_pkg.sv
// Package: shared types for the segmented up/down counter.
// Assumes: nothing beyond IEEE 1800-2017.
package ucnt_pkg;

    // Count direction encoding used on up_i and the stored last direction.
    typedef enum logic {
        CNT_DOWN = 1'b0,
        CNT_UP   = 1'b1
    } cnt_dir_e;

    // Per-segment registered value flags.
    typedef struct packed {
        logic ones;
        logic zeros;
    } seg_flags_t;

endpackage

// File: rtl/ucnt_prefix.sv
// Module: ucnt_prefix
// Purpose: for each segment, reports whether every lower segment is all
//          ones and whether every lower segment is all zeros.
// Assumes: inputs are per-segment flags. Segment 0 has no lower neighbours,
//          so both of its outputs are 1. One AND gate per segment on 1-bit flags.
module ucnt_prefix #(
    parameter int NSEG = 8
) (
    input  logic [NSEG-1:0] ones_i,
    input  logic [NSEG-1:0] zeros_i,
    output logic [NSEG-1:0] ones_below_o,
    output logic [NSEG-1:0] zeros_below_o
);

    // Seed the lowest segment: nothing below it blocks a step.
    assign ones_below_o[0]  = 1'b1;
    assign zeros_below_o[0] = 1'b1;

    genvar k;
    generate
        for (k = 1; k < NSEG; k++) begin : g_chain
            // Extend the lower-neighbour flags by one segment.
            assign ones_below_o[k]  = ones_below_o[k-1]  & ones_i[k-1];
            assign zeros_below_o[k] = zeros_below_o[k-1] & zeros_i[k-1];
        end
    endgenerate

endmodule

// File: rtl/ucnt_seg.sv
// Module: ucnt_seg
// Purpose: one SEG-bit slice of the counter. It holds its value, a shadow of
//          the value before the last enabled step, and registered
//          all-ones/all-zeros flags for its own next value.
// Assumes: step_i already says whether all lower segments permit a step
//          in the current direction. rev_i is only meaningful with en_i.
//          ld_adj_i says whether the loaded slice must be adjusted to build
//          the shadow (a borrow or carry reaches it).
module ucnt_seg
    import ucnt_pkg::*;
#(
    parameter int SEG = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en_i,
    input  logic           up_i,
    input  logic           rev_i,
    input  logic           step_i,
    input  logic           load_i,
    input  logic [SEG-1:0] ld_val_i,
    input  logic           ld_adj_i,
    output logic [SEG-1:0] val_o,
    output seg_flags_t     flags_o
);

    localparam logic [SEG-1:0] ONE = SEG'(1);

    logic [SEG-1:0] val_q, shd_q;
    logic [SEG-1:0] val_d, shd_d;
    logic [SEG-1:0] ld_shd;
    seg_flags_t     flags_q;

    // Shadow for a load: one step behind the loaded value in the load direction.
    always_comb begin
        if (!ld_adj_i)       ld_shd = ld_val_i;
        else if (up_i)       ld_shd = ld_val_i - ONE;
        else                 ld_shd = ld_val_i + ONE;
    end

    // Next value and shadow: load, reversal swap, step, or hold.
    always_comb begin
        val_d = val_q;
        shd_d = shd_q;
        if (load_i) begin
            val_d = ld_val_i;
            shd_d = ld_shd;
        end else if (en_i) begin
            shd_d = val_q;
            if (rev_i)        val_d = shd_q;
            else if (step_i)  val_d = up_i ? (val_q + ONE) : (val_q - ONE);
        end
    end

    // State registers with synchronous active-low reset (shadow = zero - 1).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q         <= '0;
            shd_q         <= '1;
            flags_q.ones  <= 1'b0;
            flags_q.zeros <= 1'b1;
        end else begin
            val_q         <= val_d;
            shd_q         <= shd_d;
            flags_q.ones  <= &val_d;
            flags_q.zeros <= ~|val_d;
        end
    end

    assign val_o   = val_q;
    assign flags_o = flags_q;

endmodule

// File: rtl/ucnt_top.sv
// Module: ucnt_top
// Purpose: WIDTH-bit synchronous up/down counter built from SEG-bit slices.
//          Steps are gated by registered per-slice flags. A change of
//          direction restores each slice's shadow instead of doing arithmetic.
// Assumes: WIDTH is a multiple of SEG. load_i has priority over en_i.
//          rst_n is synchronous and active low.
module ucnt_top
    import ucnt_pkg::*;
#(
    parameter int WIDTH = 64,
    parameter int SEG   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             up_i,
    input  logic             load_i,
    input  logic [WIDTH-1:0] load_val_i,
    output logic [WIDTH-1:0] count_o,
    output logic             tc_o
);

    localparam int NSEG = WIDTH / SEG;

    logic [NSEG-1:0] run_ones, run_zeros, run_ones_below, run_zeros_below;
    logic [NSEG-1:0] ld_ones, ld_zeros, ld_ones_below, ld_zeros_below;
    cnt_dir_e        last_dir_q;
    logic            rev;

    // Elaboration-time parameter check (R9).
    initial begin
        if (WIDTH % SEG != 0 || NSEG < 1)
            $error("ucnt_top: WIDTH must be a multiple of SEG (R9)");
    end

    // Reversal when the requested direction differs from the last step's.
    assign rev = (cnt_dir_e'(up_i) != last_dir_q);

    // Last counting direction, updated on every load or enabled step.
    always_ff @(posedge clk) begin
        if (!rst_n)                 last_dir_q <= CNT_UP;
        else if (load_i || en_i)    last_dir_q <= cnt_dir_e'(up_i);
    end

    // Lower-neighbour flags for the running count.
    ucnt_prefix #(.NSEG(NSEG)) u_run_pfx (
        .ones_i        (run_ones),
        .zeros_i       (run_zeros),
        .ones_below_o  (run_ones_below),
        .zeros_below_o (run_zeros_below)
    );

    // Lower-neighbour flags for the load value, used to seed shadows.
    ucnt_prefix #(.NSEG(NSEG)) u_ld_pfx (
        .ones_i        (ld_ones),
        .zeros_i       (ld_zeros),
        .ones_below_o  (ld_ones_below),
        .zeros_below_o (ld_zeros_below)
    );

    genvar k;
    generate
        for (k = 0; k < NSEG; k++) begin : g_seg
            seg_flags_t     flg;
            logic           step_k;
            logic           ld_adj_k;
            logic [SEG-1:0] val_k;

            // Per-slice load flags and the step / load-adjust selects.
            assign ld_ones[k]  = &load_val_i[k*SEG +: SEG];
            assign ld_zeros[k] = ~|load_val_i[k*SEG +: SEG];
            assign step_k      = up_i ? run_ones_below[k] : run_zeros_below[k];
            assign ld_adj_k    = up_i ? ld_zeros_below[k] : ld_ones_below[k];

            ucnt_seg #(.SEG(SEG)) u_seg (
                .clk      (clk),
                .rst_n    (rst_n),
                .en_i     (en_i),
                .up_i     (up_i),
                .rev_i    (rev),
                .step_i   (step_k),
                .load_i   (load_i),
                .ld_val_i (load_val_i[k*SEG +: SEG]),
                .ld_adj_i (ld_adj_k),
                .val_o    (val_k),
                .flags_o  (flg)
            );

            assign run_ones[k]            = flg.ones;
            assign run_zeros[k]           = flg.zeros;
            assign count_o[k*SEG +: SEG]  = val_k;
        end
    endgenerate

    // Terminal count for the present direction, from registered flags only.
    assign tc_o = up_i ? (run_ones_below[NSEG-1]  & run_ones[NSEG-1])
                       : (run_zeros_below[NSEG-1] & run_zeros[NSEG-1]);

endmodule

// File: rtl/ucnt_chk.sv
// Module: ucnt_chk
// Purpose: temporal checks on the counter ports and its stored direction.
// Assumes: bound into every ucnt_top instance by the bind below.
module ucnt_chk #(
    parameter int WIDTH = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_i,
    input logic             up_i,
    input logic             load_i,
    input logic [WIDTH-1:0] load_val_i,
    input logic [WIDTH-1:0] count_o,
    input logic             tc_o,
    input logic             last_up
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> (count_o == '0 && last_up == 1'b1));

    p_load_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> count_o == $past(load_val_i));

    // R3, R4, R5: every enabled step lands one away in the requested direction.
    p_step_mod_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !load_i) |=>
        count_o == ($past(up_i) ? ($past(count_o) + ONE) : ($past(count_o) - ONE)));

    p_dir_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i || load_i) |=> last_up == $past(up_i));

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !load_i) |=> ($stable(count_o) && $stable(last_up)));

    p_tc_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tc_o == ((up_i && (&count_o)) || (!up_i && (count_o == '0))));

endmodule

bind ucnt_top ucnt_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .up_i       (up_i),
    .load_i     (load_i),
    .load_val_i (load_val_i),
    .count_o    (count_o),
    .tc_o       (tc_o),
    .last_up    (last_dir_q)
);

// File: tb/sim_ucnt_top.sv
// Directed bench for ucnt_top with WIDTH = 12, SEG = 4.
module sim_ucnt_top;

    localparam int W = 12;
    localparam int S = 4;
    localparam logic [W-1:0] ALL1 = '1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0, up = 1'b1, ld = 1'b0;
    logic [W-1:0] lv = '0;
    logic [W-1:0] count;
    logic         tc;

    int n_chk = 0;
    int n_bad = 0;
    logic [W-1:0] rm = '0;

    always #2 clk = ~clk;

    ucnt_top #(.WIDTH(W), .SEG(S)) u0 (
        .clk(clk), .rst_n(rst_n), .en_i(en), .up_i(up), .load_i(ld),
        .load_val_i(lv), .count_o(count), .tc_o(tc)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock: drive at negedge, update model, sample 1 ns after posedge.
    task automatic step(input logic e, input logic u, input logic l, input logic [W-1:0] v);
        @(negedge clk);
        en = e; up = u; ld = l; lv = v;
        @(posedge clk);
        if (l)      rm = v;
        else if (e) rm = u ? rm + 1'b1 : rm - 1'b1;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; en = 1'b0; ld = 1'b0; up = 1'b1;
        @(posedge clk); @(posedge clk);
        #1;
        rm = '0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 reset count", count, '0);
        up = 1'b0; #1;
        chk("R8 tc at zero down", {11'd0, tc}, 12'd1);
        up = 1'b1; #1;
        chk("R8 tc at zero up", {11'd0, tc}, 12'd0);
    endtask

    task automatic t_reset_reverse();
        do_reset();
        step(1'b1, 1'b0, 1'b0, '0);
        chk("R7 down after reset", count, ALL1);
    endtask

    task automatic t_load();
        step(1'b1, 1'b1, 1'b1, 12'h5A3);
        chk("R2 load over enable", count, 12'h5A3);
    endtask

    task automatic t_hold();
        step(1'b0, 1'b0, 1'b0, 12'h111);
        step(1'b0, 1'b1, 1'b0, 12'h222);
        chk("R6 idle hold", count, 12'h5A3);
    endtask

    task automatic t_up_boundary();
        step(1'b0, 1'b1, 1'b1, 12'h0FF);
        step(1'b1, 1'b1, 1'b0, '0);
        chk("R3 carry across two segments", count, 12'h100);
        step(1'b1, 1'b1, 1'b0, '0);
        chk("R3 plain up", count, 12'h101);
    endtask

    task automatic t_down_boundary();
        step(1'b0, 1'b0, 1'b1, 12'h100);
        step(1'b1, 1'b0, 1'b0, '0);
        chk("R4 borrow across two segments", count, 12'h0FF);
        step(1'b1, 1'b0, 1'b0, '0);
        chk("R4 plain down", count, 12'h0FE);
    endtask

    task automatic t_wrap();
        step(1'b0, 1'b1, 1'b1, ALL1);
        up = 1'b1; #1;
        chk("R8 tc all ones up", {11'd0, tc}, 12'd1);
        step(1'b1, 1'b1, 1'b0, '0);
        chk("R3 wrap up", count, '0);
        step(1'b1, 1'b0, 1'b0, '0);
        chk("R5 reverse at wrap", count, ALL1);
        step(1'b1, 1'b1, 1'b0, '0);
        chk("R5 reverse back at wrap", count, '0);
        step(1'b1, 1'b1, 1'b0, '0);
        chk("R3 continue after reversals", count, 12'h001);
        step(1'b0, 1'b0, 1'b1, '0);
        step(1'b1, 1'b0, 1'b0, '0);
        chk("R4 wrap down", count, ALL1);
    endtask

    task automatic t_back_to_back();
        step(1'b0, 1'b1, 1'b1, 12'h3FE);
        step(1'b1, 1'b1, 1'b0, '0);
        step(1'b1, 1'b1, 1'b0, '0);
        chk("R3 up into boundary", count, 12'h400);
        for (int i = 0; i < 6; i++) begin
            step(1'b1, (i % 2) == 1, 1'b0, '0);
            chk("R5 back-to-back reversal", count, rm);
        end
    endtask

    task automatic t_pause_reverse();
        step(1'b0, 1'b0, 1'b1, 12'h0F2);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, '0);
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b0, '0);
        step(1'b1, 1'b1, 1'b0, '0);
        chk("R6 reversal after pause", count, 12'h0F0);
    endtask

    task automatic t_load_reverse();
        step(1'b0, 1'b1, 1'b1, 12'h100);
        step(1'b1, 1'b0, 1'b0, '0);
        chk("R7 down after up load", count, 12'h0FF);
        step(1'b0, 1'b0, 1'b1, 12'h0FF);
        step(1'b1, 1'b1, 1'b0, '0);
        chk("R7 up after down load", count, 12'h100);
    endtask

    task automatic t_random();
        logic [15:0] lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[7:0] == 8'h00)
                step(1'b0, lfsr[8], 1'b1, {lfsr[3:0], lfsr[11:4]});
            else
                step(lfsr[2:0] != 3'b000, lfsr[9] ^ (lfsr[4] & lfsr[5]), 1'b0, '0);
            chk("R9 random sequence", count, rm);
            chk("R8 random tc", {11'd0, tc},
                {11'd0, (up && rm == ALL1) || (!up && rm == '0)});
        end
    endtask

    initial begin
        #(4 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_reset_reverse();
        t_load();
        t_hold();
        t_up_boundary();
        t_down_boundary();
        t_wrap();
        t_back_to_back();
        t_pause_reverse();
        t_load_reverse();
        t_random();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule